// File: doc/BRIEF.md
# Serial Channel Register Front End

This block is the byte-wide register face of one asynchronous serial channel. A host reaches it through a simple chip-select, write-enable, address and data interface. The same offset can mean one register when read and a different one when written, so the status, input-port and interrupt views are read-only while the clock-select, auxiliary and mask registers are write-only at those same offsets. The two channel mode registers sit behind one offset and are reached through a pointer. That pointer starts on the first mode register and moves to the second after any access.

A write to the command offset can carry three independent orders at once: one for the receiver, one for the transmitter, and one general order. The receiver and transmitter orders are held as enable levels. The general orders either act inside the block or leave it as one-cycle pulses. The block also latches CTS change and break-change events, merges them with the ready flags of the transmitter and receiver into an interrupt status byte, masks that byte and drives one interrupt line. It sets and clears the RTS output through two separate offsets.

Serial shifting, baud generation and FIFOs sit outside this block. Their data and status appear here as ports.

The mode pointer is a two-state machine. In state PTR_MR1, any access at offset 0x00 targets mode register 1 and leads to PTR_MR2 (transition ADVANCE). In PTR_MR2, accesses target mode register 2 and the state stays put (transition HOLD). A reset-pointer command returns either state to PTR_MR1 (transition REWIND), and so does a reset.

Top module: `uart_regif`

## Requirements
- R1: After reset the following are all 0: every mode, clock-select, auxiliary, mask and transmit-data register, both enables, RTS, the interrupt line and every pulse output. The mode pointer selects mode register 1.
- R2: The first access, read or write, at offset 0x00 targets mode register 1. Every later access at 0x00 targets mode register 2 until a reset or a reset-pointer command.
- R3: A command write with general field bits[6:4] = 1 returns the mode pointer to mode register 1.
- R4: At offset 0x04 a write sets clock-select and a read returns chan_stat_i. At 0x10 a write sets the auxiliary register. Offsets 0x08, 0x38 and 0x3C and any unmapped offset read as 0.
- R5: In a command write, bits[1:0] drive the receiver enable and bits[3:2] drive the transmitter enable. In each field, 01 sets the enable, 10 clears it, and 00 or 11 leave it unchanged.
- R6: General command codes 2 to 7 each raise exactly one output for the single cycle after the write edge: 2 receiver reset, 3 transmitter reset, 4 error reset, 5 no output (it clears the break-change flag), 6 break start, 7 break stop. Code 0 raises nothing.
- R7: A write at 0x38 with bit 0 = 1 sets rts_o to 1. A write at 0x3C with bit 0 = 1 clears it. A write at either offset with bit 0 = 0 leaves rts_o unchanged.
- R8: A read at 0x10 returns bit 0 = the CTS level sampled on the previous edge and bit 4 = a latched CTS-change flag. The flag is set when cts_i differs from its last sample. The read clears it.
- R9: A brk_chg_i pulse latches the break-change flag. Only general command 5 clears it, and a new event in the same cycle wins over the clear.
- R10: A read at 0x14 returns interrupt status with bit 7 = CTS change, bit 2 = break change, bit 1 = rx_rdy_i and bit 0 = tx_rdy_i. The mask is written at 0x14. irq_o is the OR of status AND mask.
- R11: A write at 0x0C loads txd_o and pulses tx_load_o for one cycle. A read at 0x0C returns rxd_i and pulses rx_pop_o for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_i | input | 1 | Access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | AW | Byte offset |
| wdata_i | input | DW | Write data |
| rdata_o | output | DW | Read data, combinational |
| mode1_o | output | DW | Mode register 1 |
| mode2_o | output | DW | Mode register 2 |
| clksel_o | output | DW | Clock-select register |
| auxctl_o | output | DW | Auxiliary control register |
| txd_o | output | DW | Transmit byte |
| tx_load_o | output | 1 | Transmit byte load pulse |
| rxd_i | input | DW | Received byte |
| rx_pop_o | output | 1 | Received byte taken pulse |
| chan_stat_i | input | DW | Channel status byte |
| rx_en_o | output | 1 | Receiver enable |
| tx_en_o | output | 1 | Transmitter enable |
| rx_reset_o | output | 1 | Receiver reset pulse |
| tx_reset_o | output | 1 | Transmitter reset pulse |
| err_reset_o | output | 1 | Error status reset pulse |
| brk_start_o | output | 1 | Break start pulse |
| brk_stop_o | output | 1 | Break stop pulse |
| tx_rdy_i | input | 1 | Transmitter ready |
| rx_rdy_i | input | 1 | Receiver ready or full |
| brk_chg_i | input | 1 | Break start or end event |
| cts_i | input | 1 | CTS input level |
| rts_o | output | 1 | RTS output, 1 = active |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: a 6-bit address (AW = 6) and 8-bit data (DW = 8). The 6-bit address reaches every offset up to 0x3C, including the RTS set and clear offsets at the top of the space, and the unused offsets between them. With 8-bit data, every bit of the command byte can be driven. This covers the 00 and 11 enable codes, all eight general codes, and the unused high bits of the RTS writes. Random mask and ready patterns, mixed with latched CTS and break events, exercise the interrupt combine across the whole mask space.

// File: rtl/uart_regif_pkg.sv
package uart_regif_pkg;
    typedef enum logic {PTR_MR1 = 1'b0, PTR_MR2 = 1'b1} mptr_e;

    localparam int unsigned OFS_MODE  = 'h00;
    localparam int unsigned OFS_STAT  = 'h04;
    localparam int unsigned OFS_CMD   = 'h08;
    localparam int unsigned OFS_DATA  = 'h0C;
    localparam int unsigned OFS_PORT  = 'h10;
    localparam int unsigned OFS_INT   = 'h14;
    localparam int unsigned OFS_RTS1  = 'h38;
    localparam int unsigned OFS_RTS0  = 'h3C;

    typedef enum logic [2:0] {
        GC_NONE = 3'd0, GC_PTR = 3'd1, GC_RXRST = 3'd2, GC_TXRST = 3'd3,
        GC_ERRRST = 3'd4, GC_BRKCLR = 3'd5, GC_BRKON = 3'd6, GC_BRKOFF = 3'd7
    } gcmd_e;
endpackage

// File: rtl/uart_modeptr.sv
module uart_modeptr
    import uart_regif_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acc_i,
    input  logic          wr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic          rewind_i,
    output logic [DW-1:0] mr1_o,
    output logic [DW-1:0] mr2_o,
    output logic [DW-1:0] sel_o
);
    mptr_e state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            PTR_MR1: if (acc_i) state_nx = PTR_MR2;
            PTR_MR2: state_nx = PTR_MR2;
            default: state_nx = PTR_MR1;
        endcase
        if (rewind_i) state_nx = PTR_MR1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= PTR_MR1;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mr1_o <= '0;
            mr2_o <= '0;
        end else if (acc_i && wr_i) begin
            if (state == PTR_MR1) mr1_o <= wdata_i;
            else                  mr2_o <= wdata_i;
        end
    end

    assign sel_o = (state == PTR_MR1) ? mr1_o : mr2_o;

    // R2: once on mode register 2 the pointer stays there unless rewound
    a_r2_ptr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PTR_MR2 && !rewind_i) |=> (state == PTR_MR2));
    // R3: a rewind always lands on mode register 1
    a_r3_rewind: assert property (@(posedge clk) disable iff (!rst_n)
        rewind_i |=> (state == PTR_MR1));
endmodule

// File: rtl/uart_cmd_dec.sv
module uart_cmd_dec
    import uart_regif_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_wr_i,
    input  logic [6:0] cmd_i,
    output logic       rewind_o,
    output logic       brk_clr_o,
    output logic       rx_en_o,
    output logic       tx_en_o,
    output logic       rx_reset_o,
    output logic       tx_reset_o,
    output logic       err_reset_o,
    output logic       brk_start_o,
    output logic       brk_stop_o
);
    gcmd_e gc;
    logic [7:0] hit;

    assign gc = gcmd_e'(cmd_i[6:4]);

    always_comb begin
        hit = '0;
        if (cmd_wr_i) hit[gc] = 1'b1;
    end

    assign rewind_o  = hit[GC_PTR];
    assign brk_clr_o = hit[GC_BRKCLR];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_en_o <= 1'b0;
            tx_en_o <= 1'b0;
        end else if (cmd_wr_i) begin
            if (cmd_i[1:0] == 2'b01)      rx_en_o <= 1'b1;
            else if (cmd_i[1:0] == 2'b10) rx_en_o <= 1'b0;
            if (cmd_i[3:2] == 2'b01)      tx_en_o <= 1'b1;
            else if (cmd_i[3:2] == 2'b10) tx_en_o <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_reset_o  <= 1'b0;
            tx_reset_o  <= 1'b0;
            err_reset_o <= 1'b0;
            brk_start_o <= 1'b0;
            brk_stop_o  <= 1'b0;
        end else begin
            rx_reset_o  <= hit[GC_RXRST];
            tx_reset_o  <= hit[GC_TXRST];
            err_reset_o <= hit[GC_ERRRST];
            brk_start_o <= hit[GC_BRKON];
            brk_stop_o  <= hit[GC_BRKOFF];
        end
    end

    // R6: at most one general pulse at a time
    a_r6_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rx_reset_o, tx_reset_o, err_reset_o, brk_start_o, brk_stop_o}));
    // R5: receiver enable code 01 sets the enable
    a_r5_rx_on: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr_i && cmd_i[1:0] == 2'b01) |=> rx_en_o);
    // R5: transmitter disable code 10 clears the enable
    a_r5_tx_off: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr_i && cmd_i[3:2] == 2'b10) |=> !tx_en_o);
endmodule

// File: rtl/uart_irq.sv
module uart_irq #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cts_i,
    input  logic          port_rd_i,
    input  logic          brk_chg_i,
    input  logic          brk_clr_i,
    input  logic          mask_wr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic          tx_rdy_i,
    input  logic          rx_rdy_i,
    output logic [DW-1:0] isr_o,
    output logic [DW-1:0] port_o,
    output logic          irq_o
);
    logic cts_q, cos_q, brk_q;
    logic [DW-1:0] mask_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cts_q  <= 1'b0;
            cos_q  <= 1'b0;
            brk_q  <= 1'b0;
            mask_q <= '0;
        end else begin
            cts_q <= cts_i;
            if (cts_i != cts_q)  cos_q <= 1'b1;
            else if (port_rd_i)  cos_q <= 1'b0;
            if (brk_chg_i)       brk_q <= 1'b1;
            else if (brk_clr_i)  brk_q <= 1'b0;
            if (mask_wr_i)       mask_q <= wdata_i;
        end
    end

    always_comb begin
        isr_o    = '0;
        isr_o[7] = cos_q;
        isr_o[2] = brk_q;
        isr_o[1] = rx_rdy_i;
        isr_o[0] = tx_rdy_i;
        port_o    = '0;
        port_o[4] = cos_q;
        port_o[0] = cts_q;
    end

    assign irq_o = |(isr_o & mask_q);

    // R8: the CTS change flag holds until the port view is read
    a_r8_cos_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cos_q && !port_rd_i) |=> cos_q);
    // R9: the break flag holds until the clear command
    a_r9_brk_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_q && !brk_clr_i) |=> brk_q);
endmodule

// File: rtl/uart_regif.sv
module uart_regif
    import uart_regif_pkg::*;
#(
    parameter int AW = 6,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_i,
    input  logic          we_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] rdata_o,
    output logic [DW-1:0] mode1_o,
    output logic [DW-1:0] mode2_o,
    output logic [DW-1:0] clksel_o,
    output logic [DW-1:0] auxctl_o,
    output logic [DW-1:0] txd_o,
    output logic          tx_load_o,
    input  logic [DW-1:0] rxd_i,
    output logic          rx_pop_o,
    input  logic [DW-1:0] chan_stat_i,
    output logic          rx_en_o,
    output logic          tx_en_o,
    output logic          rx_reset_o,
    output logic          tx_reset_o,
    output logic          err_reset_o,
    output logic          brk_start_o,
    output logic          brk_stop_o,
    input  logic          tx_rdy_i,
    input  logic          rx_rdy_i,
    input  logic          brk_chg_i,
    input  logic          cts_i,
    output logic          rts_o,
    output logic          irq_o
);
    localparam logic [AW-1:0] A_MODE = AW'(OFS_MODE);
    localparam logic [AW-1:0] A_STAT = AW'(OFS_STAT);
    localparam logic [AW-1:0] A_CMD  = AW'(OFS_CMD);
    localparam logic [AW-1:0] A_DATA = AW'(OFS_DATA);
    localparam logic [AW-1:0] A_PORT = AW'(OFS_PORT);
    localparam logic [AW-1:0] A_INT  = AW'(OFS_INT);
    localparam logic [AW-1:0] A_RTS1 = AW'(OFS_RTS1);
    localparam logic [AW-1:0] A_RTS0 = AW'(OFS_RTS0);

    logic wr, rd;
    logic rewind, brk_clr;
    logic [DW-1:0] mode_sel, isr, port_view;

    assign wr = cs_i &  we_i;
    assign rd = cs_i & ~we_i;

    uart_modeptr #(.DW(DW)) u_modeptr (
        .clk(clk), .rst_n(rst_n),
        .acc_i(cs_i && addr_i == A_MODE), .wr_i(we_i), .wdata_i(wdata_i),
        .rewind_i(rewind), .mr1_o(mode1_o), .mr2_o(mode2_o), .sel_o(mode_sel)
    );

    uart_cmd_dec u_cmd (
        .clk(clk), .rst_n(rst_n),
        .cmd_wr_i(wr && addr_i == A_CMD), .cmd_i(wdata_i[6:0]),
        .rewind_o(rewind), .brk_clr_o(brk_clr),
        .rx_en_o(rx_en_o), .tx_en_o(tx_en_o),
        .rx_reset_o(rx_reset_o), .tx_reset_o(tx_reset_o), .err_reset_o(err_reset_o),
        .brk_start_o(brk_start_o), .brk_stop_o(brk_stop_o)
    );

    uart_irq #(.DW(DW)) u_irq (
        .clk(clk), .rst_n(rst_n), .cts_i(cts_i),
        .port_rd_i(rd && addr_i == A_PORT),
        .brk_chg_i(brk_chg_i), .brk_clr_i(brk_clr),
        .mask_wr_i(wr && addr_i == A_INT), .wdata_i(wdata_i),
        .tx_rdy_i(tx_rdy_i), .rx_rdy_i(rx_rdy_i),
        .isr_o(isr), .port_o(port_view), .irq_o(irq_o)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clksel_o  <= '0;
            auxctl_o  <= '0;
            txd_o     <= '0;
            tx_load_o <= 1'b0;
            rx_pop_o  <= 1'b0;
            rts_o     <= 1'b0;
        end else begin
            tx_load_o <= wr && addr_i == A_DATA;
            rx_pop_o  <= rd && addr_i == A_DATA;
            if (wr && addr_i == A_STAT) clksel_o <= wdata_i;
            if (wr && addr_i == A_PORT) auxctl_o <= wdata_i;
            if (wr && addr_i == A_DATA) txd_o    <= wdata_i;
            if (wr && addr_i == A_RTS1 && wdata_i[0]) rts_o <= 1'b1;
            if (wr && addr_i == A_RTS0 && wdata_i[0]) rts_o <= 1'b0;
        end
    end

    always_comb begin
        rdata_o = '0;
        if (rd) begin
            unique case (addr_i)
                A_MODE:  rdata_o = mode_sel;
                A_STAT:  rdata_o = chan_stat_i;
                A_DATA:  rdata_o = rxd_i;
                A_PORT:  rdata_o = port_view;
                A_INT:   rdata_o = isr;
                default: rdata_o = '0;
            endcase
        end
    end

    // R7: set offset with bit 0 drives RTS active
    a_r7_rts_set: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr_i == A_RTS1 && wdata_i[0]) |=> rts_o);
    // R7: clear offset with bit 0 drives RTS inactive
    a_r7_rts_clr: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr_i == A_RTS0 && wdata_i[0]) |=> !rts_o);
    // R11: the load pulse follows a transmit-buffer write
    a_r11_load: assert property (@(posedge clk) disable iff (!rst_n)
        tx_load_o |-> $past(wr && addr_i == A_DATA));
endmodule

// File: tb/uart_regif_tb.sv
module uart_regif_tb;
    logic clk = 0, rst_n = 0;
    logic cs = 0, we = 0;
    logic [5:0] addr = 0;
    logic [7:0] wdata = 0, rdata, mode1, mode2, clksel, auxctl, txd, rxd = 0, stat = 0;
    logic tx_load, rx_pop, rx_en, tx_en, rx_reset, tx_reset, err_reset, brk_start, brk_stop;
    logic tx_rdy = 0, rx_rdy = 0, brk_chg = 0, cts = 0, rts, irq;
    int checks = 0, fails = 0;
    bit cos_m = 0, brk_m = 0;

    always #10 clk = ~clk;

    uart_regif u_dut (
        .clk(clk), .rst_n(rst_n), .cs_i(cs), .we_i(we), .addr_i(addr), .wdata_i(wdata),
        .rdata_o(rdata), .mode1_o(mode1), .mode2_o(mode2), .clksel_o(clksel), .auxctl_o(auxctl),
        .txd_o(txd), .tx_load_o(tx_load), .rxd_i(rxd), .rx_pop_o(rx_pop), .chan_stat_i(stat),
        .rx_en_o(rx_en), .tx_en_o(tx_en), .rx_reset_o(rx_reset), .tx_reset_o(tx_reset),
        .err_reset_o(err_reset), .brk_start_o(brk_start), .brk_stop_o(brk_stop),
        .tx_rdy_i(tx_rdy), .rx_rdy_i(rx_rdy), .brk_chg_i(brk_chg), .cts_i(cts),
        .rts_o(rts), .irq_o(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pulses_exp(input logic [2:0] code);
        logic [7:0] p = 0;
        p[code] = 1'b1;
        return p;
    endfunction

    function automatic logic irq_exp(input logic [7:0] mask);
        logic [7:0] s = {cos_m, 4'b0, brk_m, rx_rdy, tx_rdy};
        return |(s & mask);
    endfunction

    task automatic wr(input logic [5:0] a, input logic [7:0] d);
        @(negedge clk); cs = 1; we = 1; addr = a; wdata = d;
        @(negedge clk); cs = 0; we = 0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [7:0] d);
        @(negedge clk); cs = 1; we = 0; addr = a; #1 d = rdata;
        @(negedge clk); cs = 0;
    endtask

    initial begin
        #3_000_000;
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] d, mask;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 mode", {mode1, mode2}, 0);
        chk("R1 regs", {clksel, auxctl, txd}, 0);
        chk("R1 ctl", {rx_en, tx_en, rts, irq, tx_load, rx_pop}, 0);
        chk("R1 pulses", {rx_reset, tx_reset, err_reset, brk_start, brk_stop}, 0);
        rst_n = 1;
        // R2 pointer
        wr(6'h00, 8'hA5);
        chk("R2 mr1 write", mode1, 8'hA5);
        wr(6'h00, 8'h3C);
        chk("R2 mr2 write", {mode1, mode2}, 16'hA53C);
        rd(6'h00, d); chk("R2 read mr2", d, 8'h3C);
        // R3 rewind
        wr(6'h08, 8'h10);
        rd(6'h00, d); chk("R3 read mr1 after rewind", d, 8'hA5);
        rd(6'h00, d); chk("R2 read advance", d, 8'h3C);
        // R4 shared offsets
        wr(6'h04, 8'h5D); chk("R4 clksel", clksel, 8'h5D);
        stat = 8'h96; rd(6'h04, d); chk("R4 status read", d, 8'h96);
        wr(6'h10, 8'h01); chk("R4 aux", auxctl, 8'h01);
        rd(6'h08, d); chk("R4 cmd reads 0", d, 0);
        rd(6'h38, d); chk("R4 rts1 reads 0", d, 0);
        rd(6'h20, d); chk("R4 unmapped", d, 0);
        // R5 enables
        wr(6'h08, 8'h05); chk("R5 enable both", {rx_en, tx_en}, 2'b11);
        wr(6'h08, 8'h0F); chk("R5 code 11 no effect", {rx_en, tx_en}, 2'b11);
        wr(6'h08, 8'h00); chk("R5 code 00 no effect", {rx_en, tx_en}, 2'b11);
        wr(6'h08, 8'h02); chk("R5 rx disable", {rx_en, tx_en}, 2'b01);
        wr(6'h08, 8'h08); chk("R5 tx disable", {rx_en, tx_en}, 2'b00);
        // R6 pulses for every general code
        for (int c = 0; c < 8; c++) begin
            logic [7:0] e;
            e = pulses_exp(c[2:0]);
            @(negedge clk); cs = 1; we = 1; addr = 6'h08; wdata = {1'b0, c[2:0], 4'b0};
            @(negedge clk); cs = 0; we = 0;
            chk($sformatf("R6 code %0d pulse", c),
                {rx_reset, tx_reset, err_reset, brk_start, brk_stop}, {e[2], e[3], e[4], e[6], e[7]});
            @(negedge clk);
            chk("R6 single cycle", {rx_reset, tx_reset, err_reset, brk_start, brk_stop}, 0);
        end
        // R7 RTS
        wr(6'h38, 8'hFE); chk("R7 bit0 zero ignored", rts, 0);
        wr(6'h38, 8'h01); chk("R7 set", rts, 1);
        wr(6'h3C, 8'hFE); chk("R7 clear bit0 zero ignored", rts, 1);
        wr(6'h3C, 8'h01); chk("R7 clear", rts, 0);
        // R8 CTS change
        @(negedge clk); cts = 1; @(negedge clk);
        cos_m = 1;
        rd(6'h10, d); chk("R8 port view", d, 8'h11);
        cos_m = 0;
        rd(6'h10, d); chk("R8 flag cleared by read", d, 8'h01);
        // R9 break change
        @(negedge clk); brk_chg = 1; @(negedge clk); brk_chg = 0; brk_m = 1;
        rd(6'h14, d); chk("R9 break latched", d, 8'h04);
        wr(6'h08, 8'h40); rd(6'h14, d); chk("R9 not cleared by code 4", d, 8'h04);
        @(negedge clk); cs = 1; we = 1; addr = 6'h08; wdata = 8'h50; brk_chg = 1;
        @(negedge clk); cs = 0; we = 0; brk_chg = 0;
        rd(6'h14, d); chk("R9 event wins over clear", d, 8'h04);
        wr(6'h08, 8'h50); brk_m = 0;
        rd(6'h14, d); chk("R9 cleared by code 5", d, 8'h00);
        // R11 data path
        @(negedge clk); cs = 1; we = 1; addr = 6'h0C; wdata = 8'hC3;
        @(negedge clk); cs = 0; we = 0;
        chk("R11 tx load", {tx_load, txd}, {1'b1, 8'hC3});
        @(negedge clk); chk("R11 load one cycle", tx_load, 0);
        rxd = 8'h7E;
        @(negedge clk); cs = 1; we = 0; addr = 6'h0C; #1 chk("R11 rx read", rdata, 8'h7E);
        @(negedge clk); cs = 0;
        chk("R11 rx pop", rx_pop, 1);
        @(negedge clk); chk("R11 pop one cycle", rx_pop, 0);
        // R10 random interrupt combine, with a latched CTS change and break
        @(negedge clk); cts = 0; brk_chg = 1; @(negedge clk); brk_chg = 0;
        cos_m = 1; brk_m = 1;
        for (int i = 0; i < 200; i++) begin
            mask = 8'($urandom);
            tx_rdy = 1'($urandom); rx_rdy = 1'($urandom);
            wr(6'h14, mask);
            chk("R10 irq", irq, irq_exp(mask));
            if (i % 50 == 0) begin
                rd(6'h14, d);
                chk("R10 status layout", d, {cos_m, 4'b0, brk_m, rx_rdy, tx_rdy});
            end
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule